// File: doc/BRIEF.md
# Bus Initiator Transaction Sequencer

This block runs single read or write cycles on a parallel external bus, acting as the initiator. Software first loads the words a cycle needs into a transmit FIFO: the address, and then the write data when the cycle is a write. A separate write to the command register, with the launch bit set, starts the cycle. The sequencer checks that the FIFO holds enough words and pops them. It then raises the cycle-valid line, waits a setup interval, pulses the strobe for a fixed width, and waits a hold interval before it drops the control lines.

On a read, the value on the bus input during the last strobe clock is pushed into a receive FIFO. At the end of every cycle a sticky done flag is set. Software can poll this flag or enable it as an interrupt. Two sticky error flags report two kinds of bad launch. The first is a launch while the FIFO holds too few words. The second is a launch while a cycle is already running.

Top module: `bis_top`

## Requirements
- R1: After reset, `bus_cyc`, `bus_stb`, `bus_we`, `bus_dout_en`, `tx_pop`, `rx_push` and `irq` are low, and every register reads zero.
- R2: Filling the transmit FIFO without a command write starts no cycle and pops nothing.
- R3: A launch whose FIFO has enough words (at least 1 for a read, at least 2 for a write) pops exactly that many words: the address first, then the write data.
- R4: Each cycle holds `bus_cyc` high for SETUP_CYC+STROBE_CYC+HOLD_CYC consecutive clocks. `bus_stb` is high for exactly STROBE_CYC of them, starting after SETUP_CYC clocks, and `bus_addr` stays stable throughout.
- R5: A write cycle drives `bus_we` and `bus_dout_en` high with the popped data on `bus_dout`. A read cycle leaves both low.
- R6: A read cycle makes exactly one `rx_push`, carrying the value of `bus_din` in the last strobe clock. A write cycle makes none.
- R7: Status bit 0 (done) is set when a cycle ends. It stays set until software writes 1 to that bit of the status register (address 2).
- R8: `irq` is high exactly when done is set and interrupt enable (control register, address 1, bit 0) is set.
- R9: A launch with too few FIFO words starts no cycle, pops nothing and sets status bit 1 (underflow). The flag is write-1-to-clear.
- R10: A launch written while a cycle is pending or running is ignored: it starts no extra cycle and pops nothing. It sets status bit 2 (collision), which is write-1-to-clear.
- R11: The command register (address 0) keeps the read select in bit 1. The launch bit in bit 0 reads 0 again once the sequencer has taken the command. Status bit 3 reads 1 while a command is pending or a cycle is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for write and read |
| reg_wdata | input | 4 | Register write data |
| reg_rdata | output | 4 | Register read data for `reg_addr` |
| irq | output | 1 | Completion interrupt |
| tx_level | input | LVL_W | Words held in the transmit FIFO |
| tx_data | input | DATA_W | Head word of the transmit FIFO |
| tx_pop | output | 1 | Remove the head word of the transmit FIFO |
| rx_data | output | DATA_W | Word for the receive FIFO |
| rx_push | output | 1 | Write `rx_data` into the receive FIFO |
| bus_addr | output | ADDR_W | External address |
| bus_dout | output | DATA_W | External write data |
| bus_dout_en | output | 1 | Drive enable for `bus_dout` |
| bus_din | input | DATA_W | External read data |
| bus_cyc | output | 1 | Cycle valid (control group asserted) |
| bus_stb | output | 1 | Data strobe |
| bus_we | output | 1 | Write direction |

## Verification
A wrong sequencer state shows on the bus lines within the same cycle. A stray or missing state lengthens or shortens the `bus_cyc` or `bus_stb` run, and the run is measured when it falls. An address or data word captured from the wrong FIFO slot shows as a mismatch at the first strobe clock. A capture at the wrong strobe clock shows as a wrong receive word, because the bench model changes `bus_din` on every strobe clock. A flag that is not set, not sticky, or not cleared shows on the next status read or on `irq`, one clock after the event.

// File: rtl/bis_pkg.sv
package bis_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_DATA,
      ST_SETUP,
      ST_STROBE,
      ST_HOLD
   } seq_state_t;

   localparam logic [1:0] RA_CMD  = 2'd0;
   localparam logic [1:0] RA_CTRL = 2'd1;
   localparam logic [1:0] RA_STAT = 2'd2;

   localparam int CMD_GO   = 0;
   localparam int CMD_RD   = 1;
   localparam int STA_DONE = 0;
   localparam int STA_UNF  = 1;
   localparam int STA_COLL = 2;
   localparam int STA_BUSY = 3;
endpackage

// File: rtl/bis_regs.sv
module bis_regs
   import bis_pkg::*;
#(
   parameter int REG_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [1:0]       reg_addr,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   input  logic             seq_busy,
   input  logic             accept,
   input  logic             reject,
   input  logic             done_set,
   output logic             cmd_start,
   output logic             cmd_rnw,
   output logic             irq
);
   generate
      if (REG_W < 4) begin : g_bad_w
         $error("bis_regs: REG_W must be at least 4");
      end
   endgenerate

   logic irq_en, done_q, unf_q, coll_q, lock;
   logic cmd_wr, ctrl_wr, stat_wr;

   assign lock    = seq_busy | cmd_start;
   assign cmd_wr  = reg_wr && (reg_addr == RA_CMD);
   assign ctrl_wr = reg_wr && (reg_addr == RA_CTRL);
   assign stat_wr = reg_wr && (reg_addr == RA_STAT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_start <= 1'b0;
         cmd_rnw   <= 1'b0;
         irq_en    <= 1'b0;
         done_q    <= 1'b0;
         unf_q     <= 1'b0;
         coll_q    <= 1'b0;
      end else begin
         if (cmd_wr && !lock) begin
            cmd_start <= reg_wdata[CMD_GO];
            cmd_rnw   <= reg_wdata[CMD_RD];
         end else if (accept || reject) begin
            cmd_start <= 1'b0;
         end
         if (ctrl_wr) irq_en <= reg_wdata[0];

         if (done_set) done_q <= 1'b1;
         else if (stat_wr && reg_wdata[STA_DONE]) done_q <= 1'b0;

         if (reject) unf_q <= 1'b1;
         else if (stat_wr && reg_wdata[STA_UNF]) unf_q <= 1'b0;

         if (cmd_wr && lock && reg_wdata[CMD_GO]) coll_q <= 1'b1;
         else if (stat_wr && reg_wdata[STA_COLL]) coll_q <= 1'b0;
      end
   end

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         RA_CMD: begin
            reg_rdata[CMD_GO] = cmd_start;
            reg_rdata[CMD_RD] = cmd_rnw;
         end
         RA_CTRL: reg_rdata[0] = irq_en;
         RA_STAT: begin
            reg_rdata[STA_DONE] = done_q;
            reg_rdata[STA_UNF]  = unf_q;
            reg_rdata[STA_COLL] = coll_q;
            reg_rdata[STA_BUSY] = lock;
         end
         default: reg_rdata = '0;
      endcase
   end

   assign irq = done_q & irq_en;

   logic unused_wdata;
   assign unused_wdata = ^reg_wdata;

   // R7: done holds until a write-1 clear
   a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !(stat_wr && reg_wdata[STA_DONE])) |=> done_q);
   // R10: a launch during a locked period raises collision
   a_r10_collision_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && lock && reg_wdata[CMD_GO]) |=> coll_q);
   // R11: launch bit drops once taken
   a_r11_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (accept || reject) |=> !cmd_start);
   // R9: a refused launch raises underflow
   a_r9_underflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
      reject |=> unf_q);
endmodule

// File: rtl/bis_seq.sv
module bis_seq
   import bis_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 32,
   parameter int LVL_W      = 4,
   parameter int SETUP_CYC  = 2,
   parameter int STROBE_CYC = 3,
   parameter int HOLD_CYC   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_start,
   input  logic              cmd_rnw,
   output logic              accept,
   output logic              reject,
   output logic              seq_busy,
   output logic              done_set,
   input  logic [LVL_W-1:0]  tx_level,
   input  logic [DATA_W-1:0] tx_data,
   output logic              tx_pop,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_push,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_dout,
   output logic              bus_dout_en,
   input  logic [DATA_W-1:0] bus_din,
   output logic              bus_cyc,
   output logic              bus_stb,
   output logic              bus_we
);
   localparam int MAX_A = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
   localparam int MAX_C = (MAX_A > HOLD_CYC) ? MAX_A : HOLD_CYC;
   localparam int CW    = (MAX_C > 1) ? $clog2(MAX_C) : 1;
   localparam logic [CW-1:0] LD_SETUP  = CW'(SETUP_CYC - 1);
   localparam logic [CW-1:0] LD_STROBE = CW'(STROBE_CYC - 1);
   localparam logic [CW-1:0] LD_HOLD   = CW'(HOLD_CYC - 1);

   generate
      if (SETUP_CYC < 1 || STROBE_CYC < 1 || HOLD_CYC < 1) begin : g_bad_time
         $error("bis_seq: every timing phase needs at least one clock");
      end
      if (ADDR_W > DATA_W) begin : g_bad_addr
         $error("bis_seq: ADDR_W may not exceed DATA_W");
      end
      if (LVL_W < 2) begin : g_bad_lvl
         $error("bis_seq: LVL_W must be at least 2");
      end
   endgenerate

   seq_state_t state;
   logic [CW-1:0]     cnt;
   logic              we_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic              words_ok, last;

   assign words_ok = cmd_rnw ? (tx_level != '0) : (tx_level > LVL_W'(1));
   assign accept   = (state == ST_IDLE) && cmd_start && words_ok;
   assign reject   = (state == ST_IDLE) && cmd_start && !words_ok;
   assign last     = (cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cnt    <= '0;
         we_q   <= 1'b0;
         addr_q <= '0;
         data_q <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (accept) begin
               state <= ST_ADDR;
               we_q  <= !cmd_rnw;
            end
            ST_ADDR: begin
               addr_q <= tx_data[ADDR_W-1:0];
               state  <= we_q ? ST_DATA : ST_SETUP;
               cnt    <= LD_SETUP;
            end
            ST_DATA: begin
               data_q <= tx_data;
               state  <= ST_SETUP;
               cnt    <= LD_SETUP;
            end
            ST_SETUP: if (last) begin
               state <= ST_STROBE;
               cnt   <= LD_STROBE;
            end else cnt <= cnt - 1'b1;
            ST_STROBE: if (last) begin
               state <= ST_HOLD;
               cnt   <= LD_HOLD;
            end else cnt <= cnt - 1'b1;
            ST_HOLD: if (last) state <= ST_IDLE;
               else cnt <= cnt - 1'b1;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign seq_busy    = (state != ST_IDLE);
   assign tx_pop      = (state == ST_ADDR) || (state == ST_DATA);
   assign bus_cyc     = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);
   assign bus_stb     = (state == ST_STROBE);
   assign bus_we      = bus_cyc && we_q;
   assign bus_dout_en = bus_we;
   assign bus_addr    = addr_q;
   assign bus_dout    = data_q;
   assign rx_push     = bus_stb && last && !we_q;
   assign rx_data     = bus_din;
   assign done_set    = (state == ST_HOLD) && last;

   // R4: strobe only inside a cycle
   a_r4_stb_in_cyc: assert property (@(posedge clk) disable iff (!rst_n)
      bus_stb |-> bus_cyc);
   // R4: address steady across the cycle
   a_r4_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cyc && $past(bus_cyc)) |-> $stable(bus_addr));
   // R3: never pop an empty FIFO
   a_r3_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
      tx_pop |-> (tx_level != '0));
   // R6: receive pushes only in read strobes
   a_r6_push_read_only: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push |-> (bus_stb && !bus_we));
   // R9: a refused launch leaves the sequencer idle
   a_r9_reject_idle: assert property (@(posedge clk) disable iff (!rst_n)
      reject |=> !seq_busy);
endmodule

// File: rtl/bis_top.sv
module bis_top #(
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 32,
   parameter int LVL_W      = 4,
   parameter int SETUP_CYC  = 2,
   parameter int STROBE_CYC = 3,
   parameter int HOLD_CYC   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_addr,
   input  logic [3:0]        reg_wdata,
   output logic [3:0]        reg_rdata,
   output logic              irq,
   input  logic [LVL_W-1:0]  tx_level,
   input  logic [DATA_W-1:0] tx_data,
   output logic              tx_pop,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_push,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_dout,
   output logic              bus_dout_en,
   input  logic [DATA_W-1:0] bus_din,
   output logic              bus_cyc,
   output logic              bus_stb,
   output logic              bus_we
);
   logic cmd_start, cmd_rnw, accept, reject, seq_busy, done_set;

   bis_regs #(.REG_W(4)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .seq_busy  (seq_busy),
      .accept    (accept),
      .reject    (reject),
      .done_set  (done_set),
      .cmd_start (cmd_start),
      .cmd_rnw   (cmd_rnw),
      .irq       (irq)
   );

   bis_seq #(
      .DATA_W     (DATA_W),
      .ADDR_W     (ADDR_W),
      .LVL_W      (LVL_W),
      .SETUP_CYC  (SETUP_CYC),
      .STROBE_CYC (STROBE_CYC),
      .HOLD_CYC   (HOLD_CYC)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_start   (cmd_start),
      .cmd_rnw     (cmd_rnw),
      .accept      (accept),
      .reject      (reject),
      .seq_busy    (seq_busy),
      .done_set    (done_set),
      .tx_level    (tx_level),
      .tx_data     (tx_data),
      .tx_pop      (tx_pop),
      .rx_data     (rx_data),
      .rx_push     (rx_push),
      .bus_addr    (bus_addr),
      .bus_dout    (bus_dout),
      .bus_dout_en (bus_dout_en),
      .bus_din     (bus_din),
      .bus_cyc     (bus_cyc),
      .bus_stb     (bus_stb),
      .bus_we      (bus_we)
   );
endmodule

// File: tb/bis_top_tb.sv
module bis_top_tb;
   localparam int CLK_P  = 10;
   localparam int DW     = 32;
   localparam int LW     = 4;
   localparam int S_CYC  = 2;
   localparam int T_CYC  = 3;
   localparam int H_CYC  = 1;
   localparam logic [31:0] KEY = 32'h5A5A_0F0F;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_wr = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic [3:0] reg_wdata = 4'd0;
   logic [3:0] reg_rdata;
   logic irq, tx_pop, rx_push, bus_dout_en, bus_cyc, bus_stb, bus_we;
   logic [LW-1:0] tx_level;
   logic [DW-1:0] tx_data, rx_data, bus_dout, bus_din, bus_addr;

   always #(CLK_P/2) clk = ~clk;

   int checks = 0;
   int errors = 0;

   // transmit FIFO model
   logic [DW-1:0] tx_mem [16];
   logic [3:0] wp = 4'd0;
   logic [3:0] rp = 4'd0;
   assign tx_level = wp - rp;
   assign tx_data  = tx_mem[rp];
   always @(posedge clk) if (tx_pop) rp <= rp + 4'd1;

   // target model: read value moves on every strobe clock
   int stb_idx = 0;
   always @(posedge clk) stb_idx <= bus_stb ? stb_idx + 1 : 0;
   assign bus_din = bus_stb ? ((bus_addr ^ KEY) + 32'(stb_idx)) : 32'hDEAD_BEEF;

   bis_top #(.DATA_W(DW), .ADDR_W(DW), .LVL_W(LW),
             .SETUP_CYC(S_CYC), .STROBE_CYC(T_CYC), .HOLD_CYC(H_CYC)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
      .tx_level(tx_level), .tx_data(tx_data), .tx_pop(tx_pop),
      .rx_data(rx_data), .rx_push(rx_push), .bus_addr(bus_addr),
      .bus_dout(bus_dout), .bus_dout_en(bus_dout_en), .bus_din(bus_din),
      .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_we(bus_we));

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // scoreboard
   typedef struct { bit we; logic [31:0] addr; logic [31:0] data; } item_t;
   item_t exp_q[$];
   item_t cur;
   int n_cycles = 0, n_pops = 0, n_push = 0;
   int cyc_len = 0, stb_len = 0, setup_len = 0, push_in_cyc = 0;
   bit seen_stb = 0, prev_stb = 0, prev_cyc = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (tx_pop) n_pops++;
         if (rx_push) n_push++;
         if (bus_cyc) begin
            cyc_len++;
            if (bus_stb) begin stb_len++; seen_stb = 1; end
            else if (!seen_stb) setup_len++;
         end
         if (bus_stb && !prev_stb) begin
            if (exp_q.size() == 0) begin
               chk(0, "R2 unexpected bus cycle", bus_addr, 0);
            end else begin
               cur = exp_q.pop_front();
               chk(bus_we == cur.we, "R5 direction", 32'(bus_we), 32'(cur.we));
               chk(bus_addr == cur.addr, "R3 address order", bus_addr, cur.addr);
               if (cur.we) begin
                  chk(bus_dout == cur.data, "R5 write data", bus_dout, cur.data);
                  chk(bus_dout_en, "R5 drive enable", 32'(bus_dout_en), 1);
               end else
                  chk(!bus_dout_en, "R5 no drive on read", 32'(bus_dout_en), 0);
            end
         end
         if (rx_push) begin
            push_in_cyc++;
            chk(rx_data == cur.data, "R6 read capture", rx_data, cur.data);
         end
         if (!bus_cyc && prev_cyc) begin
            n_cycles++;
            chk(cyc_len == S_CYC+T_CYC+H_CYC, "R4 cycle width", 32'(cyc_len), 32'(S_CYC+T_CYC+H_CYC));
            chk(stb_len == T_CYC, "R4 strobe width", 32'(stb_len), 32'(T_CYC));
            chk(setup_len == S_CYC, "R4 setup width", 32'(setup_len), 32'(S_CYC));
            chk(push_in_cyc == (cur.we ? 0 : 1), "R6 push count", 32'(push_in_cyc), cur.we ? 0 : 1);
            cyc_len = 0; stb_len = 0; setup_len = 0; push_in_cyc = 0; seen_stb = 0;
         end
         prev_stb = bus_stb;
         prev_cyc = bus_cyc;
      end
   end

   task automatic reg_write(input logic [1:0] a, input logic [3:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [1:0] a, output logic [3:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic push_tx(input logic [31:0] w);
      @(negedge clk);
      tx_mem[wp] = w;
      wp = wp + 4'd1;
   endtask

   task automatic wait_idle();
      logic [3:0] s;
      for (int i = 0; i < 200; i++) begin
         reg_read(2'd2, s);
         if (!s[3]) break;
      end
   endtask

   task automatic do_write(input logic [31:0] a, input logic [31:0] d);
      item_t it;
      it.we = 1; it.addr = a; it.data = d;
      exp_q.push_back(it);
      push_tx(a); push_tx(d);
      reg_write(2'd0, 4'b0001);
   endtask

   task automatic do_read(input logic [31:0] a);
      item_t it;
      it.we = 0; it.addr = a; it.data = (a ^ KEY) + 32'(T_CYC - 1);
      exp_q.push_back(it);
      push_tx(a);
      reg_write(2'd0, 4'b0011);
   endtask

   bit finished = 0;
   initial begin
      #(CLK_P * 150000);
      if (!finished) begin
         chk(0, "watchdog", 0, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [3:0] r;
      int c0, p0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!bus_cyc && !bus_stb && !bus_we && !bus_dout_en && !tx_pop && !rx_push && !irq,
          "R1 idle outputs", {bus_cyc, bus_stb, bus_we, bus_dout_en, tx_pop, rx_push, irq}, 0);
      reg_read(2'd0, r); chk(r == 0, "R1 command reg", 32'(r), 0);
      reg_read(2'd1, r); chk(r == 0, "R1 control reg", 32'(r), 0);
      reg_read(2'd2, r); chk(r == 0, "R1 status reg", 32'(r), 0);

      // R2 FIFO load alone starts nothing
      push_tx(32'h0000_1040); push_tx(32'hCAFE_0001);
      repeat (10) @(negedge clk);
      chk(n_cycles == 0 && n_pops == 0, "R2 no launch", 32'(n_cycles + n_pops), 0);
      chk(tx_level == 2, "R2 level kept", 32'(tx_level), 2);

      // write cycle using the preloaded words
      begin
         item_t it; it.we = 1; it.addr = 32'h0000_1040; it.data = 32'hCAFE_0001;
         exp_q.push_back(it);
      end
      reg_write(2'd0, 4'b0001);
      reg_read(2'd0, r);
      chk(r == 4'b0000, "R11 launch bit self-clears", 32'(r), 0);
      reg_read(2'd2, r);
      chk(r[3] == 1'b1, "R11 busy while running", 32'(r), 4'b1000);
      wait_idle();
      chk(n_cycles == 1, "R3 one write cycle", 32'(n_cycles), 1);
      chk(n_pops == 2 && tx_level == 0, "R3 write pops two", 32'(n_pops), 2);
      reg_read(2'd2, r); chk(r == 4'b0001, "R7 done set", 32'(r), 1);
      chk(!irq, "R8 irq masked", 32'(irq), 0);
      repeat (3) @(negedge clk);
      reg_read(2'd2, r); chk(r[0], "R7 done sticky", 32'(r), 1);
      reg_write(2'd2, 4'b0001);
      reg_read(2'd2, r); chk(r == 0, "R7 done cleared", 32'(r), 0);

      // read cycle with interrupt enabled
      reg_write(2'd1, 4'b0001);
      do_read(32'h0000_2204);
      wait_idle();
      chk(n_cycles == 2 && n_pops == 3, "R3 read pops one", 32'(n_pops), 3);
      chk(n_push == 1, "R6 one receive word", 32'(n_push), 1);
      @(negedge clk);
      chk(irq, "R8 irq raised", 32'(irq), 1);
      reg_read(2'd0, r); chk(r == 4'b0010, "R11 read select kept", 32'(r), 2);
      reg_write(2'd2, 4'b0001);
      @(negedge clk);
      chk(!irq, "R8 irq drops on clear", 32'(irq), 0);

      // R9 underflow: empty FIFO read launch
      c0 = n_cycles; p0 = n_pops;
      reg_write(2'd0, 4'b0011);
      repeat (8) @(negedge clk);
      reg_read(2'd2, r); chk(r == 4'b0010, "R9 underflow on read", 32'(r), 2);
      chk(n_cycles == c0 && n_pops == p0, "R9 no cycle", 32'(n_cycles - c0), 0);
      reg_write(2'd2, 4'b0010);
      reg_read(2'd2, r); chk(r == 0, "R9 underflow cleared", 32'(r), 0);

      // R9 underflow: write launch with one word
      push_tx(32'h0000_3300);
      reg_write(2'd0, 4'b0001);
      repeat (8) @(negedge clk);
      reg_read(2'd2, r); chk(r[1], "R9 underflow on write", 32'(r), 2);
      chk(tx_level == 1 && n_pops == p0, "R9 word kept", 32'(tx_level), 1);
      reg_write(2'd2, 4'b0010);
      begin
         item_t it; it.we = 1; it.addr = 32'h0000_3300; it.data = 32'h1234_5678;
         exp_q.push_back(it);
      end
      push_tx(32'h1234_5678);
      reg_write(2'd0, 4'b0001);
      wait_idle();
      chk(n_cycles == c0 + 1, "R3 write after refill", 32'(n_cycles - c0), 1);
      reg_write(2'd2, 4'b0001);

      // R10 collision: launch during a running cycle
      c0 = n_cycles;
      push_tx(32'h0000_4400); push_tx(32'h0BAD_F00D); push_tx(32'h0000_5500);
      begin
         item_t it; it.we = 1; it.addr = 32'h0000_4400; it.data = 32'h0BAD_F00D;
         exp_q.push_back(it);
      end
      reg_write(2'd0, 4'b0001);
      repeat (2) @(negedge clk);
      reg_write(2'd0, 4'b0011);
      wait_idle();
      repeat (4) @(negedge clk);
      chk(n_cycles == c0 + 1, "R10 extra launch ignored", 32'(n_cycles - c0), 1);
      chk(tx_level == 1, "R10 spare word kept", 32'(tx_level), 1);
      reg_read(2'd2, r); chk(r == 4'b0101, "R10 collision flag", 32'(r), 5);
      reg_read(2'd0, r); chk(r == 4'b0000, "R10 command unchanged", 32'(r), 0);
      reg_write(2'd2, 4'b0101);
      reg_read(2'd2, r); chk(r == 0, "R10 collision cleared", 32'(r), 0);

      // consume the spare word with a read
      begin
         item_t it; it.we = 0; it.addr = 32'h0000_5500; it.data = (32'h0000_5500 ^ KEY) + 32'(T_CYC - 1);
         exp_q.push_back(it);
      end
      reg_write(2'd0, 4'b0011);
      wait_idle();
      chk(n_push == 2, "R6 second receive word", 32'(n_push), 2);

      // back-to-back reads and writes of varied patterns
      do_write(32'hFFFF_FFFC, 32'h0000_0000);
      wait_idle();
      do_read(32'h8000_0000);
      wait_idle();
      repeat (3) @(negedge clk);
      chk(exp_q.size() == 0, "R3 all cycles seen", 32'(exp_q.size()), 0);
      chk(tx_level == 0, "R3 FIFO drained", 32'(tx_level), 0);

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule